// File: doc/BRIEF.md
# Dual-Channel GPIO with Change Interrupt

This block is a register-mapped general-purpose I/O peripheral with up to two channels. Each channel has an output latch and a direction latch, and each pin can be an input or an output. A register bus reads and writes the block in one cycle: address, write strobe and write data in, and read data returned combinationally for the address presented. Input pins pass through a two-flop synchroniser before anything else uses them.

An interrupt unit watches the synchronised inputs. When any pin of a channel that is set as an input changes level, in either direction, that channel's status bit is set. The status bit stays set until software writes a 1 to it. The interrupt output is a level. It is high while the master enable is set and at least one pending status bit is also enabled. The second channel is present only when the dual-channel parameter is set.

The house state-machine style does not apply here. The block has no sequencing, so the control is a register decode that selects one of a set of named register targets.

Top module: `dual_gpio_ctrl`

## Requirements
- R1: After reset each output latch holds its reset parameter, each direction latch holds its reset parameter (default all ones, all inputs), and status, per-channel enable, master enable and the interrupt output are all 0.
- R2: Byte offsets: channel A data 0x000, channel A direction 0x004, channel B data 0x008, channel B direction 0x00C. Both direction latches read back what was written.
- R3: A direction bit of 1 makes the pin an input: its output enable is 0 and its output value is 0. A direction bit of 0 makes it an output: its output enable is 1 and it drives the output latch bit.
- R4: Reading a data register returns, for each bit, the synchronised pin level when the bit is an input and the output latch bit when it is an output.
- R5: A pin change driven before a clock edge appears in the data register read after the second following edge, and not after the first.
- R6: The status register is at 0x120, with bit 0 for channel A and bit 1 for channel B. A level change in either direction on any input-direction pin sets the channel's bit after the third edge that follows the pin change. Changes on output-direction pins set nothing. The bit stays set until it is cleared.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged, so writing back a value just read clears exactly the pending bits.
- R8: Per-channel enables are at 0x128 (bit 0 channel A, bit 1 channel B) and the master enable is bit 31 of 0x11C. The interrupt output equals master enable AND (status AND enable is non-zero).
- R9: Unimplemented addresses, data and direction bits above a channel's width (channel B defaults to 20 bits), enable bits above bit 1, and master-enable bits other than bit 31 all read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| a_pin_i | input | A_W | Channel A pin levels in |
| a_pin_o | output | A_W | Channel A pin drive values |
| a_pin_oe | output | A_W | Channel A output enables, 1 = drive |
| b_pin_i | input | B_W | Channel B pin levels in |
| b_pin_o | output | B_W | Channel B pin drive values |
| b_pin_oe | output | B_W | Channel B output enables, 1 = drive |
| irq | output | 1 | Level interrupt request |

## Verification
The bench aims at the synchroniser and detection latency. A design with one flop too few or too many shows the new pin level, or sets the status bit, one edge off from the counted cycle. It toggles pins that are set as outputs, which catches a detector that ignores direction and raises spurious status. It writes back partial status masks, which catches clear logic that wipes every bit or treats the write as a plain store. It writes to unimplemented offsets and to the bits above channel B's 20 bits, which catches a decoder that aliases addresses or keeps bits that do not exist.

// File: rtl/dual_gpio_pkg.sv
package dual_gpio_pkg;

    typedef enum logic [2:0] {
        SEL_A_DAT,
        SEL_A_DIR,
        SEL_B_DAT,
        SEL_B_DIR,
        SEL_MASTER,
        SEL_STATUS,
        SEL_ENABLE,
        SEL_NONE
    } reg_sel_e;

    localparam int unsigned OFF_A_DAT  = 'h000;
    localparam int unsigned OFF_A_DIR  = 'h004;
    localparam int unsigned OFF_B_DAT  = 'h008;
    localparam int unsigned OFF_B_DIR  = 'h00C;
    localparam int unsigned OFF_MASTER = 'h11C;
    localparam int unsigned OFF_STATUS = 'h120;
    localparam int unsigned OFF_ENABLE = 'h128;

    function automatic reg_sel_e decode(input int unsigned addr, input bit dual);
        reg_sel_e s;
        s = SEL_NONE;
        if (addr == OFF_A_DAT)                s = SEL_A_DAT;
        else if (addr == OFF_A_DIR)           s = SEL_A_DIR;
        else if (addr == OFF_B_DAT && dual)   s = SEL_B_DAT;
        else if (addr == OFF_B_DIR && dual)   s = SEL_B_DIR;
        else if (addr == OFF_MASTER)          s = SEL_MASTER;
        else if (addr == OFF_STATUS)          s = SEL_STATUS;
        else if (addr == OFF_ENABLE)          s = SEL_ENABLE;
        return s;
    endfunction

endpackage

// File: rtl/gpio_chan.sv
module gpio_chan #(
    parameter int unsigned W        = 32,
    parameter logic [31:0] DOUT_RST = 32'h0,
    parameter logic [31:0] DIR_RST  = 32'hFFFF_FFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dat,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_dat,
    output logic [W-1:0] rd_dir,
    output logic         chg
);
    logic [W-1:0] dout_q, dir_q, sync1_q, sync2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= DOUT_RST[W-1:0];
            dir_q   <= DIR_RST[W-1:0];
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            if (wr_dat) dout_q <= wdata;
            if (wr_dir) dir_q  <= wdata;
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    always_comb begin
        pin_oe = ~dir_q;
        pin_o  = dout_q & ~dir_q;
        rd_dat = (dir_q & sync2_q) | (~dir_q & dout_q);
        rd_dir = dir_q;
        chg    = |((sync2_q ^ prev_q) & dir_q);
    end

    // R3: the output enable follows the complement of the written direction
    assert_oe_follows_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (pin_oe == ~$past(wdata)));

    // R3: an input-direction pin is never driven
    assert_input_undriven_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_o & ~pin_oe) == '0));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter bit DUAL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] chg,
    input  logic       status_we,
    input  logic       enable_we,
    input  logic       master_we,
    input  logic [1:0] wbits,
    input  logic       wmaster,
    output logic [1:0] status,
    output logic [1:0] enable,
    output logic       master,
    output logic       irq
);
    localparam logic [1:0] CH_MASK = DUAL ? 2'b11 : 2'b01;

    logic [1:0] clr;

    always_comb clr = status_we ? wbits : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= 2'b00;
            enable <= 2'b00;
            master <= 1'b0;
        end else begin
            status <= ((status & ~clr) | chg) & CH_MASK;
            if (enable_we) enable <= wbits & CH_MASK;
            if (master_we) master <= wmaster;
        end
    end

    always_comb irq = master & (|(status & enable));

    // R6: a detected change on channel A always shows up in status
    assert_status_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chg[0] |=> status[0]);

    // R6: a pending bit survives any cycle that does not clear it
    assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !clr[0]) |=> status[0]);

    // R7: a write of 1 with no new change clears the bit
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[0] && !chg[0]) |=> !status[0]);

    // R8: the request only rises while the master enable is set
    assert_irq_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> master);

endmodule

// File: rtl/dual_gpio_ctrl.sv
module dual_gpio_ctrl
    import dual_gpio_pkg::*;
#(
    parameter int unsigned ADDR_W     = 9,
    parameter bit          DUAL       = 1'b1,
    parameter int unsigned A_W        = 32,
    parameter int unsigned B_W        = 20,
    parameter logic [31:0] A_DOUT_RST = 32'h0,
    parameter logic [31:0] A_DIR_RST  = 32'hFFFF_FFFF,
    parameter logic [31:0] B_DOUT_RST = 32'h0,
    parameter logic [31:0] B_DIR_RST  = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [A_W-1:0]    a_pin_i,
    output logic [A_W-1:0]    a_pin_o,
    output logic [A_W-1:0]    a_pin_oe,
    input  logic [B_W-1:0]    b_pin_i,
    output logic [B_W-1:0]    b_pin_o,
    output logic [B_W-1:0]    b_pin_oe,
    output logic              irq
);
    reg_sel_e        sel;
    logic [A_W-1:0]  a_rd_dat, a_rd_dir;
    logic [B_W-1:0]  b_rd_dat, b_rd_dir;
    logic [31:0]     a_dat_x, a_dir_x, b_dat_x, b_dir_x;
    logic [1:0]      chg, status, enable;
    logic            master;

    always_comb sel = decode(int'(reg_addr), DUAL);

    gpio_chan #(.W(A_W), .DOUT_RST(A_DOUT_RST), .DIR_RST(A_DIR_RST)) u_chan_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_dat (reg_we && sel == SEL_A_DAT),
        .wr_dir (reg_we && sel == SEL_A_DIR),
        .wdata  (reg_wdata[A_W-1:0]),
        .pin_i  (a_pin_i),
        .pin_o  (a_pin_o),
        .pin_oe (a_pin_oe),
        .rd_dat (a_rd_dat),
        .rd_dir (a_rd_dir),
        .chg    (chg[0])
    );

    generate
        if (DUAL) begin : g_chan_b
            gpio_chan #(.W(B_W), .DOUT_RST(B_DOUT_RST), .DIR_RST(B_DIR_RST)) u_chan_b (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_dat (reg_we && sel == SEL_B_DAT),
                .wr_dir (reg_we && sel == SEL_B_DIR),
                .wdata  (reg_wdata[B_W-1:0]),
                .pin_i  (b_pin_i),
                .pin_o  (b_pin_o),
                .pin_oe (b_pin_oe),
                .rd_dat (b_rd_dat),
                .rd_dir (b_rd_dir),
                .chg    (chg[1])
            );
        end else begin : g_no_chan_b
            assign b_pin_o  = '0;
            assign b_pin_oe = '0;
            assign b_rd_dat = '0;
            assign b_rd_dir = '0;
            assign chg[1]   = 1'b0;
        end
    endgenerate

    gpio_irq_unit #(.DUAL(DUAL)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg       (chg),
        .status_we (reg_we && sel == SEL_STATUS),
        .enable_we (reg_we && sel == SEL_ENABLE),
        .master_we (reg_we && sel == SEL_MASTER),
        .wbits     (reg_wdata[1:0]),
        .wmaster   (reg_wdata[31]),
        .status    (status),
        .enable    (enable),
        .master    (master),
        .irq       (irq)
    );

    always_comb begin
        a_dat_x = '0; a_dat_x[A_W-1:0] = a_rd_dat;
        a_dir_x = '0; a_dir_x[A_W-1:0] = a_rd_dir;
        b_dat_x = '0; b_dat_x[B_W-1:0] = b_rd_dat;
        b_dir_x = '0; b_dir_x[B_W-1:0] = b_rd_dir;
    end

    always_comb begin
        unique case (sel)
            SEL_A_DAT:  reg_rdata = a_dat_x;
            SEL_A_DIR:  reg_rdata = a_dir_x;
            SEL_B_DAT:  reg_rdata = b_dat_x;
            SEL_B_DIR:  reg_rdata = b_dir_x;
            SEL_MASTER: reg_rdata = {master, 31'b0};
            SEL_STATUS: reg_rdata = {30'b0, status};
            SEL_ENABLE: reg_rdata = {30'b0, enable};
            default:    reg_rdata = '0;
        endcase
    end

    // R9: an address outside the map always reads zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (reg_rdata == 32'h0));

    // R8: an enabled pending status with the master set raises the request
    assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (master && (status[0] && enable[0])) |-> irq);

endmodule

// File: tb/test_dual_gpio_ctrl.sv
`timescale 1ns/1ps
module test_dual_gpio_ctrl;
    localparam int A_W = 32;
    localparam int B_W = 20;
    localparam logic [31:0] B_MASK = 32'h000F_FFFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [8:0]        reg_addr = '0;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [A_W-1:0]    a_pin_i = '0;
    logic [A_W-1:0]    a_pin_o, a_pin_oe;
    logic [B_W-1:0]    b_pin_i = '0;
    logic [B_W-1:0]    b_pin_o, b_pin_oe;
    logic              irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] m_adat, m_adir, m_bdat, m_bdir, m_pa, m_pb;
    logic [1:0]  m_stat, m_ier;
    logic        m_gie;

    always #2.5 clk = ~clk;

    dual_gpio_ctrl i_dual_gpio_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .a_pin_i(a_pin_i), .a_pin_o(a_pin_o), .a_pin_oe(a_pin_oe),
        .b_pin_i(b_pin_i), .b_pin_o(b_pin_o), .b_pin_oe(b_pin_oe),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [31:0] dat, input logic [31:0] dir,
                                             input logic [31:0] pin);
        return (dir & pin) | (~dir & dat);
    endfunction

    function automatic logic exp_irq();
        return m_gie & (|(m_stat & m_ier));
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic check_all(input string ctx);
        logic [31:0] v;
        rd(9'h000, v); chk({"R4 A data ", ctx}, v, exp_read(m_adat, m_adir, m_pa));
        rd(9'h004, v); chk({"R2 A dir ", ctx}, v, m_adir);
        rd(9'h008, v); chk({"R4 R9 B data ", ctx}, v, exp_read(m_bdat, m_bdir, m_pb) & B_MASK);
        rd(9'h00C, v); chk({"R2 R9 B dir ", ctx}, v, m_bdir & B_MASK);
        rd(9'h11C, v); chk({"R8 R9 master ", ctx}, v, {m_gie, 31'b0});
        rd(9'h120, v); chk({"R6 status ", ctx}, v, {30'b0, m_stat});
        rd(9'h128, v); chk({"R8 R9 enable ", ctx}, v, {30'b0, m_ier});
        chk({"R3 A oe ", ctx}, a_pin_oe, ~m_adir);
        chk({"R3 A out ", ctx}, a_pin_o, m_adat & ~m_adir);
        chk({"R3 B oe ", ctx}, 32'(b_pin_oe), ~m_bdir & B_MASK);
        chk({"R3 B out ", ctx}, 32'(b_pin_o), m_bdat & ~m_bdir & B_MASK);
        chk({"R8 irq ", ctx}, 32'(irq), 32'(exp_irq()));
    endtask

    task automatic set_pins(input logic [31:0] pa, input logic [31:0] pb);
        @(negedge clk);
        if (((pa ^ m_pa) & m_adir) != 0) m_stat[0] = 1'b1;
        if (((pb ^ m_pb) & m_bdir & B_MASK) != 0) m_stat[1] = 1'b1;
        m_pa = pa; m_pb = pb & B_MASK;
        a_pin_i = pa; b_pin_i = pb[B_W-1:0];
        tick(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, r;
        void'($urandom(32'd4242));
        m_adat = 0; m_adir = '1; m_bdat = 0; m_bdir = B_MASK;
        m_pa = 0; m_pb = 0; m_stat = 0; m_ier = 0; m_gie = 0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check_all("reset R1");

        // R5 and R6: latency of synchroniser and detector
        @(negedge clk);
        a_pin_i = 32'h0000_0010;
        @(posedge clk); #1;
        rd(9'h000, v); chk("R5 not visible after one edge", v, 32'h0);
        @(posedge clk); #1;
        rd(9'h000, v); chk("R5 visible after two edges", v, 32'h10);
        rd(9'h120, v); chk("R6 status not yet after two edges", v, 32'h0);
        @(posedge clk); #1;
        rd(9'h120, v); chk("R6 status set after three edges", v, 32'h1);
        m_pa = 32'h10; m_stat = 2'b01;
        tick(2);
        check_all("latency");

        // R6: falling edge also sets; clear first
        wr(9'h120, 32'h1); m_stat = 0;
        check_all("clear before fall R7");
        set_pins(32'h0, 32'h0);
        check_all("falling edge R6");

        // R6: output-direction pin change does not set status
        wr(9'h120, 32'h3); m_stat = 0;
        wr(9'h004, 32'hFFFF_FF00); m_adir = 32'hFFFF_FF00;
        set_pins(32'h0000_00A5, 32'h0);
        check_all("output pin toggle R6");

        // R7: partial write-back and write-back of read value
        set_pins(32'h0000_01A5, 32'h0000_0001);
        check_all("both pending R6");
        wr(9'h120, 32'h2); m_stat[1] = 1'b0;
        check_all("clear only B R7");
        set_pins(32'h0000_03A5, 32'h0000_0003);
        rd(9'h120, r);
        wr(9'h120, r); m_stat = 0;
        check_all("write back read value R7");

        // R8: interrupt gating
        wr(9'h128, 32'hFFFF_FFFF); m_ier = 2'b11;
        set_pins(32'h0000_07A5, 32'h3);
        check_all("pending no master R8");
        wr(9'h11C, 32'h7FFF_FFFF); m_gie = 0;
        check_all("master bit 30..0 ignored R9");
        wr(9'h11C, 32'h8000_0000); m_gie = 1;
        check_all("irq high R8");
        wr(9'h128, 32'h2); m_ier = 2'b10;
        check_all("A pending but disabled R8");

        // R9: unmapped addresses
        wr(9'h010, 32'hFFFF_FFFF);
        wr(9'h124, 32'hFFFF_FFFF);
        wr(9'h1FC, 32'hFFFF_FFFF);
        rd(9'h010, v); chk("R9 unmapped 0x010", v, 0);
        rd(9'h124, v); chk("R9 unmapped 0x124", v, 0);
        rd(9'h1FC, v); chk("R9 unmapped 0x1FC", v, 0);
        rd(9'h002, v); chk("R9 unaligned 0x002", v, 0);
        check_all("after unmapped writes R9");
        wr(9'h00C, 32'hFFFF_FFFF); m_bdir = B_MASK;
        wr(9'h008, 32'hFFFF_FFFF); m_bdat = B_MASK;
        check_all("B upper bits R9");

        // random phase
        for (int it = 0; it < 300; it++) begin
            logic [31:0] w;
            w = $urandom;
            case ($urandom % 8)
                0: begin wr(9'h000, w); m_adat = w; end
                1: begin wr(9'h004, w); m_adir = w; end
                2: begin wr(9'h008, w); m_bdat = w & B_MASK; end
                3: begin wr(9'h00C, w); m_bdir = w & B_MASK; end
                4: begin wr(9'h128, w); m_ier = w[1:0]; end
                5: begin wr(9'h11C, w); m_gie = w[31]; end
                6: begin wr(9'h120, w); m_stat = m_stat & ~w[1:0]; end
                default: set_pins(w ^ (32'h1 << ($urandom % 32)), $urandom);
            endcase
            check_all($sformatf("random %0d R2 R3 R4 R6 R7 R8", it));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule